// File: doc/BRIEF.md
# Periodic Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. It watches a free-running 64-bit main counter supplied from outside. When the counter equals its 64-bit comparator, it raises a one-cycle interrupt pulse. In periodic mode the comparator then advances by a stored period, so events repeat at a fixed interval. Software reaches the channel over a 32-bit register bus. Every 64-bit quantity is therefore handled as two naturally aligned dwords, low dword first.

The channel's central feature is a consistent split load. With the load-period control armed in periodic mode, the low-dword write is held in a staging register. The following high-dword write commits the full 64-bit value to the comparator and the period together, and only then disarms the control. The full width is writable, including bit 63. A narrow mode restricts matching, reload arithmetic and visible state to the low 32 bits. Counter reads are tear-free: a low-dword read captures the upper half for the high-dword read that follows.

Top module: `ptc_channel`

## Requirements
- R1: After reset, the configuration reads 0, the comparator reads 0xFFFFFFFF in both dwords, the period reads 0 and `irq_o` is low.
- R2: The configuration register is at offset 0x00, with these fields:
    - bit 3 is periodic enable;
    - bit 6 is the load-period control, which a write of 1 arms and a write of 0 disarms;
    - bit 8 is narrow (32-bit) mode.
  All other configuration bits read 0.
- R3: With the load-period control not armed, a write to the comparator low dword (0x08) or high dword (0x0C) changes only that half of the comparator and leaves the period unchanged.
- R4: In 64-bit periodic mode with the load-period control armed, a low-dword comparator write leaves the comparator unchanged. The following high-dword write loads the comparator and the period with {high, low}, and the control then reads 0. Example: writing 0x01234567 and then 0x00001234 makes both read 0x00001234_01234567.
- R5: In 64-bit mode every bit of the comparator and the period is writable, including bit 63.
- R6: In narrow mode:
    - writes to the comparator high dword are ignored;
    - the comparator and period high dwords (0x0C, 0x1C) read 0;
    - an armed low-dword write loads the low halves of the comparator and the period at once and disarms the control;
    - the upper half of the period keeps its value, which is seen after returning to 64-bit mode.
- R7: When the counter equals the comparator (all 64 bits, or the low 32 bits in narrow mode), `irq_o` is high in the following cycle for exactly one cycle. It stays low while the counter remains at the matching value.
- R8: On a match in periodic mode, the comparator becomes comparator plus period, modulo 2^64 in 64-bit mode. In narrow mode the low 32 bits become their sum modulo 2^32.
- R9: On a match with periodic mode off, the comparator is unchanged.
- R10: A read of counter low (0x10) returns the live counter bits 31:0 and captures bits 63:32. A read of counter high (0x14) returns the captured upper half.
- R11: The period is readable at 0x18 (low) and 0x1C (high). A read of any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| counter_i | input | 64 | Free-running main counter value |
| irq_o | output | 1 | One-cycle match interrupt pulse |

## Verification
On every cycle the assertions check the following:
- the interrupt never lasts more than one cycle;
- an armed high-dword commit leaves the comparator and the period equal, and disarms the control;
- a staged low write leaves the comparator untouched;
- narrow-mode high writes change nothing;
- a 64-bit periodic reload adds the period;
- a counter-low read captures the upper half.

Only the directed scenarios can show the results that depend on specific values. These include:
- the exact split-load example value and bit 63 surviving;
- wrap-around in both widths;
- the upper period half surviving a narrow-mode load;
- the edge-only pulse when the counter dwells on a match;
- one-shot comparator stability;
- unmapped offsets reading zero.

// File: rtl/ptc_pkg.sv
// Shared definitions for the periodic timer comparator channel.
// Assumes a byte-addressed 32-bit register bus with an 8-bit offset.
package ptc_pkg;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CMP_LO = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CMP_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_PER_LO = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_PER_HI = 8'h1C;

    localparam int unsigned BIT_PERIODIC = 3;
    localparam int unsigned BIT_LOADPER  = 6;
    localparam int unsigned BIT_NARROW   = 8;

    typedef struct packed {
        logic narrow;
        logic loadper;
        logic periodic;
    } chan_cfg_t;
endpackage

// File: rtl/ptc_regs.sv
// Register file of one comparator channel: configuration, comparator,
// period and the low-dword staging register for split 64-bit loads.
// Assumes at most one bus write per cycle; bus writes take priority over
// a reload in the same cycle.
module ptc_regs
    import ptc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned WIDE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              reload_fire,
    output chan_cfg_t         cfg_q,
    output logic [WIDE_W-1:0] comp_q,
    output logic [WIDE_W-1:0] period_q
);
    logic              wr_cfg, wr_lo, wr_hi, armed;
    logic              stage_lo, commit_hi, commit_narrow;
    logic [DATA_W-1:0] stage_q;

    // Decode the write target and the split-load actions.
    always_comb begin
        wr_cfg        = bus_wr && (bus_addr == OFF_CFG);
        wr_lo         = bus_wr && (bus_addr == OFF_CMP_LO);
        wr_hi         = bus_wr && (bus_addr == OFF_CMP_HI);
        armed         = cfg_q.loadper && cfg_q.periodic;
        stage_lo      = wr_lo && armed && !cfg_q.narrow;
        commit_hi     = wr_hi && armed && !cfg_q.narrow;
        commit_narrow = wr_lo && armed && cfg_q.narrow;
    end

    // Configuration; the load-period control disarms after a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q.periodic <= bus_wdata[BIT_PERIODIC];
            cfg_q.loadper  <= bus_wdata[BIT_LOADPER];
            cfg_q.narrow   <= bus_wdata[BIT_NARROW];
        end else if (commit_hi || commit_narrow) begin
            cfg_q.loadper <= 1'b0;
        end
    end

    // Hold the low dword of an armed 64-bit load until its high dword.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (stage_lo)
            stage_q <= bus_wdata;
    end

    // Comparator: bus writes first, then the periodic reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_q <= '1;
        end else if (commit_hi) begin
            comp_q <= {bus_wdata, stage_q};
        end else if (wr_lo) begin
            if (!stage_lo)
                comp_q[DATA_W-1:0] <= bus_wdata;
        end else if (wr_hi) begin
            if (!cfg_q.narrow)
                comp_q[WIDE_W-1:DATA_W] <= bus_wdata;
        end else if (reload_fire) begin
            if (cfg_q.narrow)
                comp_q[DATA_W-1:0] <= comp_q[DATA_W-1:0] + period_q[DATA_W-1:0];
            else
                comp_q <= comp_q + period_q;
        end
    end

    // Period: loaded only through an armed comparator write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_q <= '0;
        else if (commit_hi)
            period_q <= {bus_wdata, stage_q};
        else if (commit_narrow)
            period_q[DATA_W-1:0] <= bus_wdata;
    end

    a_r4_commit_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        commit_hi |=> (comp_q == period_q));
    a_r4_loadper_clears: assert property (@(posedge clk) disable iff (!rst_n)
        commit_hi |=> !cfg_q.loadper);
    a_r4_stage_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stage_lo |=> $stable(comp_q));
    a_r6_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && cfg_q.narrow) |=> ($stable(comp_q[WIDE_W-1:DATA_W]) && $stable(period_q)));
    a_r8_reload_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_fire && !bus_wr && !cfg_q.narrow) |=> (comp_q == $past(comp_q + period_q)));
endmodule

// File: rtl/ptc_match.sv
// Match detector: compares the counter with the comparator at the
// selected width, emits a one-cycle interrupt on the rising edge of a
// match and requests a reload in periodic mode.
module ptc_match #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned WIDE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDE_W-1:0] counter_i,
    input  logic [WIDE_W-1:0] comp_q,
    input  logic              narrow,
    input  logic              periodic,
    output logic              reload_fire,
    output logic              irq_o
);
    logic hit, hit_q;

    // Width-selected equality and the reload request.
    always_comb begin
        if (narrow)
            hit = (counter_i[DATA_W-1:0] == comp_q[DATA_W-1:0]);
        else
            hit = (counter_i == comp_q);
        reload_fire = hit && periodic;
    end

    // Edge-detect the match into a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            irq_o <= 1'b0;
        end else begin
            hit_q <= hit;
            irq_o <= hit && !hit_q;
        end
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
endmodule

// File: rtl/ptc_snap.sv
// Counter snapshot: captures the counter's upper half on a low-dword
// read so that the following high-dword read is tear-free.
module ptc_snap
    import ptc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] counter_hi,
    output logic [DATA_W-1:0] snap_q
);
    logic take;

    // A read of the counter low dword triggers the capture.
    always_comb take = bus_rd && (bus_addr == OFF_CNT_LO);

    // Capture register for the counter upper half.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (take)
            snap_q <= counter_hi;
    end

    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (snap_q == $past(counter_hi)));
endmodule

// File: rtl/ptc_channel.sv
// Top of one periodic timer comparator channel. Ties the register file,
// the match detector and the counter snapshot together and drives the
// combinational read mux. Assumes the counter is supplied from outside.
module ptc_channel
    import ptc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned WIDE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [WIDE_W-1:0] counter_i,
    output logic              irq_o
);
    chan_cfg_t         cfg_q;
    logic [WIDE_W-1:0] comp_q, period_q;
    logic [DATA_W-1:0] snap_q, cfg_word;
    logic              reload_fire;

    ptc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .reload_fire(reload_fire),
        .cfg_q(cfg_q), .comp_q(comp_q), .period_q(period_q)
    );

    ptc_match #(.DATA_W(DATA_W)) u_match (
        .clk(clk), .rst_n(rst_n), .counter_i(counter_i), .comp_q(comp_q),
        .narrow(cfg_q.narrow), .periodic(cfg_q.periodic),
        .reload_fire(reload_fire), .irq_o(irq_o)
    );

    ptc_snap #(.DATA_W(DATA_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .counter_hi(counter_i[WIDE_W-1:DATA_W]), .snap_q(snap_q)
    );

    // Pack the configuration fields into their bus positions.
    always_comb begin
        cfg_word               = '0;
        cfg_word[BIT_PERIODIC] = cfg_q.periodic;
        cfg_word[BIT_LOADPER]  = cfg_q.loadper;
        cfg_word[BIT_NARROW]   = cfg_q.narrow;
    end

    // Read mux; upper halves are hidden in narrow mode.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFF_CFG:    bus_rdata = cfg_word;
                OFF_CMP_LO: bus_rdata = comp_q[DATA_W-1:0];
                OFF_CMP_HI: bus_rdata = cfg_q.narrow ? '0 : comp_q[WIDE_W-1:DATA_W];
                OFF_CNT_LO: bus_rdata = counter_i[DATA_W-1:0];
                OFF_CNT_HI: bus_rdata = snap_q;
                OFF_PER_LO: bus_rdata = period_q[DATA_W-1:0];
                OFF_PER_HI: bus_rdata = cfg_q.narrow ? '0 : period_q[WIDE_W-1:DATA_W];
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: tb/sim_ptc_channel.sv
`timescale 1ns/1ps
module sim_ptc_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] counter_i = 64'h5555;
    logic        irq_o;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    ptc_channel u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .counter_i(counter_i), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    // Put the counter at a value, check the pulse after the next edge.
    task automatic hit_at(input string tag, input logic [63:0] c);
        @(negedge clk);
        counter_i = c;
        @(posedge clk);
        #1 check({tag, " pulse"}, {31'b0, irq_o}, 32'd1);
    endtask

    task automatic t_reset;
        check("R1 irq", {31'b0, irq_o}, 32'd0);
        expect_rd("R1 cfg", 8'h00, 32'h0);
        expect_rd("R1 cmp lo", 8'h08, 32'hFFFF_FFFF);
        expect_rd("R1 cmp hi", 8'h0C, 32'hFFFF_FFFF);
        expect_rd("R1 per lo", 8'h18, 32'h0);
        expect_rd("R1 per hi", 8'h1C, 32'h0);
    endtask

    task automatic t_cfg;
        wr(8'h00, 32'hFFFF_FFFF);
        expect_rd("R2 cfg all ones", 8'h00, 32'h0000_0148);
        wr(8'h00, 32'h0);
        expect_rd("R2 cfg cleared", 8'h00, 32'h0);
    endtask

    task automatic t_direct;
        wr(8'h08, 32'hAAAA_5555);
        expect_rd("R3 lo written", 8'h08, 32'hAAAA_5555);
        expect_rd("R3 hi kept", 8'h0C, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h1234_5678);
        expect_rd("R3 hi written", 8'h0C, 32'h1234_5678);
        expect_rd("R3 lo kept", 8'h08, 32'hAAAA_5555);
        expect_rd("R3 period untouched", 8'h18, 32'h0);
    endtask

    task automatic t_split;
        wr(8'h00, 32'h48);
        wr(8'h08, 32'h0123_4567);
        expect_rd("R4 lo staged, cmp unchanged", 8'h08, 32'hAAAA_5555);
        expect_rd("R4 still armed", 8'h00, 32'h48);
        wr(8'h0C, 32'h0000_1234);
        expect_rd("R4 cmp lo", 8'h08, 32'h0123_4567);
        expect_rd("R4 cmp hi", 8'h0C, 32'h0000_1234);
        expect_rd("R4 per lo", 8'h18, 32'h0123_4567);
        expect_rd("R4 per hi", 8'h1C, 32'h0000_1234);
        expect_rd("R4 disarmed", 8'h00, 32'h08);
    endtask

    task automatic t_bit63;
        wr(8'h00, 32'h48);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h8000_0001);
        expect_rd("R5 cmp hi", 8'h0C, 32'h8000_0001);
        expect_rd("R5 per hi", 8'h1C, 32'h8000_0001);
    endtask

    task automatic t_periodic;
        wr(8'h00, 32'h48);
        wr(8'h08, 32'd100);
        wr(8'h0C, 32'h0);
        hit_at("R7 periodic", 64'd100);
        @(negedge clk);
        counter_i = 64'd101;
        @(posedge clk);
        #1 check("R7 pulse ends", {31'b0, irq_o}, 32'd0);
        expect_rd("R8 cmp advanced", 8'h08, 32'd200);
        hit_at("R7 second", 64'd200);
        expect_rd("R8 cmp advanced again", 8'h08, 32'd300);
        // 64-bit wrap: comparator = period = 2^63
        wr(8'h00, 32'h48);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h8000_0000);
        hit_at("R7 wrap", 64'h8000_0000_0000_0000);
        @(negedge clk);
        counter_i = 64'h5555;
        expect_rd("R8 wrap lo", 8'h08, 32'h0);
        expect_rd("R8 wrap hi", 8'h0C, 32'h0);
    endtask

    task automatic t_oneshot;
        wr(8'h00, 32'h0);
        wr(8'h08, 32'd50);
        wr(8'h0C, 32'h0);
        hit_at("R7 one-shot", 64'd50);
        @(posedge clk);
        #1 check("R7 no repeat while dwelling", {31'b0, irq_o}, 32'd0);
        expect_rd("R9 cmp unchanged", 8'h08, 32'd50);
        @(negedge clk);
        counter_i = 64'h5555;
    endtask

    task automatic t_narrow;
        wr(8'h00, 32'h148);
        wr(8'h08, 32'h10);
        expect_rd("R6 disarmed by low write", 8'h00, 32'h108);
        expect_rd("R6 cmp lo loaded", 8'h08, 32'h10);
        expect_rd("R6 per lo loaded", 8'h18, 32'h10);
        expect_rd("R6 cmp hi reads 0", 8'h0C, 32'h0);
        expect_rd("R6 per hi reads 0", 8'h1C, 32'h0);
        wr(8'h0C, 32'h0000_DEAD);
        hit_at("R7 narrow match", 64'hFFFF_FFFF_0000_0010);
        expect_rd("R8 narrow advance", 8'h08, 32'h20);
        wr(8'h08, 32'hFFFF_FFF8);
        hit_at("R7 narrow wrap", 64'h0000_0000_FFFF_FFF8);
        @(negedge clk);
        counter_i = 64'h7;
        expect_rd("R8 narrow wrap mod 2^32", 8'h08, 32'h8);
        wr(8'h00, 32'h08);
        expect_rd("R6 period upper kept", 8'h1C, 32'h8000_0000);
        expect_rd("R6 period lower", 8'h18, 32'h10);
        expect_rd("R6 ignored high write", 8'h0C, 32'h0);
    endtask

    task automatic t_snap;
        @(negedge clk);
        counter_i = 64'h1111_2222_3333_4444;
        expect_rd("R10 live low", 8'h10, 32'h3333_4444);
        @(negedge clk);
        counter_i = 64'h9999_0000_0000_0000;
        expect_rd("R10 captured high", 8'h14, 32'h1111_2222);
    endtask

    task automatic t_unmapped;
        expect_rd("R11 offset 0x04", 8'h04, 32'h0);
        expect_rd("R11 offset 0x20", 8'h20, 32'h0);
        expect_rd("R11 offset 0x3C", 8'h3C, 32'h0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_direct();
        t_split();
        t_bit63();
        t_periodic();
        t_oneshot();
        t_narrow();
        t_snap();
        t_unmapped();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule